// File: doc/BRIEF.md
# Channel Status Field Decoder

This block watches the channel status bit that rides in every audio frame of a serial digital audio receiver, once for each of the two subframes (A and B). At a block-start frame it begins collecting the first sixteen channel status bits of the selected subframe. After the sixteenth bit has been collected it decodes them into a small status register and pulses an update strobe. The register holds three flags: professional format, copy, and original.

The original flag follows the copy-management rules for consumer data. The generation bit is read with a polarity that depends on the category group. In most groups a set generation bit marks an original. In a group that a parameter mask lists, a clear generation bit marks an original. When the stream is in professional format, the copy and original flags are both forced low.

The register changes in one step, one cycle after the last captured frame. Frames that arrive after that are ignored until the next block start. A new block start restarts the capture at any time, so a block that is cut short never reaches the register.

Top module: `cs_status_decoder`

## Requirements
- R1: While reset is low, and after it, until the first update, `stat_pro`, `stat_copy`, `stat_orig` and `stat_upd` are 0.
- R2: A frame is accepted when `frame_valid` is 1. A capture begins with an accepted frame that has `blk_start` high, and this frame supplies bit 0. Later accepted frames supply bits 1 to 15 in order. `stat_upd` is high for exactly one cycle: the cycle that follows the clock edge after the edge that accepted bit 15. The flags change only in that cycle. There is no update before the first block start.
- R3: The value of `sel_b` on the block-start frame picks the source for the whole block: 0 selects `cs_a` and 1 selects `cs_b`. Changes to `sel_b` during the rest of the block have no effect.
- R4: `stat_pro` equals channel status bit 0 of the selected subframe.
- R5: In consumer format (bit 0 = 0), `stat_copy` equals channel status bit 2.
- R6: In consumer format, the category group index is bit8·4 + bit9·2 + bit10. If bit `g` of `INV_GROUP_MASK` is 0, `stat_orig` equals bit 15. If that bit is 1, `stat_orig` equals the inverse of bit 15. The default mask is 8'h86, so groups 1, 2 and 7 are inverted.
- R7: When bit 0 is 1, `stat_copy` and `stat_orig` are 0.
- R8: Accepted frames after bit 15 and before the next block start leave the flags unchanged and raise no `stat_upd`.
- R9: A block start that arrives before bit 15 restarts the capture at bit 0. The cut-short block produces no update.
- R10: Cycles with `frame_valid` low are ignored, whatever the values of `cs_a`, `cs_b`, `blk_start` and `sel_b` in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_valid | input | 1 | Frame strobe; the bits below are taken in this cycle |
| blk_start | input | 1 | Marks the first frame of a channel status block |
| sel_b | input | 1 | Source select, sampled at block start: 0 = A, 1 = B |
| cs_a | input | 1 | Channel status bit of subframe A |
| cs_b | input | 1 | Channel status bit of subframe B |
| stat_pro | output | 1 | Professional-format flag |
| stat_copy | output | 1 | Copy flag (consumer only) |
| stat_orig | output | 1 | Original flag from category and generation bit |
| stat_upd | output | 1 | One-cycle pulse when the flags are refreshed |

## Verification
The bench builds the block with the default field positions and the default inversion mask 8'h86. This mask lets the vectors reach both generation-bit polarities: inverted groups 1, 2 and 7 against plain groups 0, 3 and 4. The sixteen-frame window from bit position 15 lets the bench place frames past the window and cut a block short at frame seven. The bench also feeds opposite data to the unselected subframe and to idle cycles. This shows that the select latch and the frame strobe really gate what is captured.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    // Decoded receiver status flags
    typedef struct packed {
        logic pro;
        logic copy;
        logic orig;
    } cs_flags_t;

endpackage

// File: rtl/cs_bit_capture.sv
module cs_bit_capture #(
    parameter int CAP_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_valid,
    input  logic                blk_start,
    input  logic                sel_b,
    input  logic                cs_a,
    input  logic                cs_b,
    output logic                cap_done,
    output logic [CAP_BITS-1:0] cap_word
);

    localparam int IDX_W = (CAP_BITS > 1) ? $clog2(CAP_BITS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CAP_BITS - 1);

    typedef struct packed {
        logic                active;
        logic                sel;
        logic [IDX_W-1:0]    idx;
        logic [CAP_BITS-1:0] word;
        logic                done;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       pick_bit;
    logic       first_bit;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        pick_bit  = st_q.sel ? cs_b : cs_a;
        first_bit = sel_b ? cs_b : cs_a;
        if (frame_valid) begin
            if (blk_start) begin
                st_d.active  = 1'b1;
                st_d.sel     = sel_b;
                st_d.word    = '0;
                st_d.word[0] = first_bit;
                st_d.idx     = IDX_W'(1);
            end else if (st_q.active) begin
                st_d.word[st_q.idx] = pick_bit;
                if (st_q.idx == LAST_IDX) begin
                    st_d.active = 1'b0;
                    st_d.done   = 1'b1;
                    st_d.idx    = '0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_done = st_q.done;
    assign cap_word = st_q.word;

endmodule

// File: rtl/cs_field_decode.sv
module cs_field_decode
    import cs_dec_pkg::*;
#(
    parameter int CAP_BITS = 16,
    parameter int PRO_POS  = 0,
    parameter int COPY_POS = 2,
    parameter int CAT_LSB  = 8,
    parameter int GEN_POS  = 15,
    parameter int GRP_W    = 3,
    parameter logic [(1<<GRP_W)-1:0] INV_GROUP_MASK = 8'h86
) (
    input  logic [CAP_BITS-1:0] word,
    output cs_flags_t           flags
);

    logic [GRP_W-1:0] grp;
    logic             inv;
    logic             pro;
    logic             unused_bits;

    // First category bit on the wire is the group MSB
    for (genvar g = 0; g < GRP_W; g++) begin : g_grp
        assign grp[GRP_W-1-g] = word[CAT_LSB+g];
    end

    always_comb begin
        pro         = word[PRO_POS];
        inv         = INV_GROUP_MASK[grp];
        flags.pro   = pro;
        flags.copy  = !pro && word[COPY_POS];
        flags.orig  = !pro && (word[GEN_POS] ^ inv);
        unused_bits = ^word;
    end

endmodule

// File: rtl/cs_status_decoder.sv
module cs_status_decoder
    import cs_dec_pkg::*;
#(
    parameter int PRO_POS  = 0,
    parameter int COPY_POS = 2,
    parameter int CAT_LSB  = 8,
    parameter int GEN_POS  = 15,
    parameter int GRP_W    = 3,
    parameter logic [(1<<GRP_W)-1:0] INV_GROUP_MASK = 8'h86
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_valid,
    input  logic blk_start,
    input  logic sel_b,
    input  logic cs_a,
    input  logic cs_b,
    output logic stat_pro,
    output logic stat_copy,
    output logic stat_orig,
    output logic stat_upd
);

    localparam int CAP_BITS = GEN_POS + 1;

    typedef struct packed {
        cs_flags_t flags;
        logic      upd;
    } stat_reg_t;

    logic                cap_done;
    logic [CAP_BITS-1:0] cap_word;
    cs_flags_t           dec_flags;
    stat_reg_t           st_d, st_q;

    cs_bit_capture #(
        .CAP_BITS (CAP_BITS)
    ) i_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .blk_start   (blk_start),
        .sel_b       (sel_b),
        .cs_a        (cs_a),
        .cs_b        (cs_b),
        .cap_done    (cap_done),
        .cap_word    (cap_word)
    );

    cs_field_decode #(
        .CAP_BITS       (CAP_BITS),
        .PRO_POS        (PRO_POS),
        .COPY_POS       (COPY_POS),
        .CAT_LSB        (CAT_LSB),
        .GEN_POS        (GEN_POS),
        .GRP_W          (GRP_W),
        .INV_GROUP_MASK (INV_GROUP_MASK)
    ) i_decode (
        .word  (cap_word),
        .flags (dec_flags)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upd = cap_done;
        if (cap_done) begin
            st_d.flags = dec_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_pro  = st_q.flags.pro;
    assign stat_copy = st_q.flags.copy;
    assign stat_orig = st_q.flags.orig;
    assign stat_upd  = st_q.upd;

endmodule

// File: rtl/cs_status_checker.sv
module cs_status_checker #(
    parameter int CAP_BITS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic frame_valid,
    input logic blk_start,
    input logic stat_pro,
    input logic stat_copy,
    input logic stat_orig,
    input logic stat_upd,
    input logic cap_done
);

    logic [7:0] frm_cnt_q;

    // Frames accepted since the latest block start, 0 before any start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_cnt_q <= '0;
        end else if (frame_valid) begin
            if (blk_start) begin
                frm_cnt_q <= 8'd1;
            end else if (frm_cnt_q != 8'd0 && frm_cnt_q != 8'hFF) begin
                frm_cnt_q <= frm_cnt_q + 8'd1;
            end
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !stat_upd && !stat_pro && !stat_copy && !stat_orig);

    a_r7_pro_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_pro |-> !stat_copy && !stat_orig);

    a_r8_hold_between_updates: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_upd |-> $stable({stat_pro, stat_copy, stat_orig}));

    a_r2_done_then_update: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> stat_upd);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        stat_upd |=> !stat_upd);

    // R9: a restart resets the frame count, so a cut block cannot reach sixteen
    a_r9_update_after_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        stat_upd |-> $past(frm_cnt_q) == 8'(CAP_BITS));

endmodule

bind cs_status_decoder cs_status_checker #(
    .CAP_BITS (CAP_BITS)
) i_cs_status_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .blk_start   (blk_start),
    .stat_pro    (stat_pro),
    .stat_copy   (stat_copy),
    .stat_orig   (stat_orig),
    .stat_upd    (stat_upd),
    .cap_done    (cap_done)
);

// File: tb/test_cs_status_decoder.sv
module test_cs_status_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {sel, word_a, word_b, expected {pro, copy, orig}}; bit i of a word is cs bit i
    localparam logic [35:0] VECS [NVEC] = '{
        {1'b0, 16'h8004, 16'h0001, 3'b011},  // R5 R6 group 0, L=1 -> orig
        {1'b1, 16'h8004, 16'h8400, 3'b000},  // R3 B, R6 group 1 inverted, L=1
        {1'b1, 16'h0000, 16'h0404, 3'b011},  // R6 group 1 inverted, L=0 -> orig
        {1'b0, 16'h8005, 16'h0000, 3'b100},  // R4 R7 pro forces zero
        {1'b0, 16'h0200, 16'hFFFF, 3'b001},  // R6 group 2 inverted, L=0
        {1'b0, 16'h8704, 16'h0000, 3'b010},  // R6 group 7 inverted, L=1
        {1'b1, 16'h8004, 16'h0100, 3'b000},  // R6 group 4 plain, L=0
        {1'b0, 16'h8600, 16'h0005, 3'b001}   // R6 group 3 plain, L=1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_valid = 1'b0;
    logic blk_start = 1'b0;
    logic sel_b = 1'b0;
    logic cs_a = 1'b0;
    logic cs_b = 1'b0;
    logic stat_pro, stat_copy, stat_orig, stat_upd;

    int checks = 0;
    int fails = 0;
    int upd_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_status_decoder i_cs_status_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .blk_start   (blk_start),
        .sel_b       (sel_b),
        .cs_a        (cs_a),
        .cs_b        (cs_b),
        .stat_pro    (stat_pro),
        .stat_copy   (stat_copy),
        .stat_orig   (stat_orig),
        .stat_upd    (stat_upd)
    );

    always @(negedge clk) if (rst_n && stat_upd) upd_seen++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic fv, input logic bs, input logic s,
                       input logic ba, input logic bb);
        @(negedge clk);
        frame_valid = fv;
        blk_start   = bs;
        sel_b       = s;
        cs_a        = ba;
        cs_b        = bb;
    endtask

    // Frame 0 carries the block start; later frames drive the opposite select (R3)
    task automatic send_block(input logic s, input logic [15:0] a, input logic [15:0] b,
                              input int nfr, input int gap);
        for (int i = 0; i < nfr; i++) begin
            if (i > 0) begin
                for (int g = 0; g < gap; g++) put(1'b0, 1'b1, s, ~a[i], ~b[i]);
            end
            put(1'b1, i == 0, (i == 0) ? s : ~s, a[i], b[i]);
        end
    endtask

    task automatic after_block(input logic [2:0] exp, input string tag);
        put(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check({tag, " R2 no update one cycle after bit 15"}, {31'd0, stat_upd}, 32'd0);
        put(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check({tag, " R2 update strobe"}, {31'd0, stat_upd}, 32'd1);
        check({tag, " R4 R5 R6 R7 flags"}, {29'd0, stat_pro, stat_copy, stat_orig}, {29'd0, exp});
        put(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check({tag, " R2 single pulse"}, {31'd0, stat_upd}, 32'd0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int seen0;
        logic [2:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset flags", {29'd0, stat_pro, stat_copy, stat_orig}, 32'd0);
        check("R1 reset strobe", {31'd0, stat_upd}, 32'd0);
        rst_n = 1'b1;

        // R2: frames with no block start never update
        for (int i = 0; i < 20; i++) put(1'b1, 1'b0, i[0], 1'b1, 1'b1);
        put(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        put(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        #(CLK_PERIOD/4);
        check("R2 no update before first block start", upd_seen, 0);
        check("R1 flags stay clear", {29'd0, stat_pro, stat_copy, stat_orig}, 32'd0);

        // Vector table; gaps exercise R10
        for (int k = 0; k < NVEC; k++) begin
            send_block(VECS[k][35], VECS[k][34:19], VECS[k][18:3], 16, k % 3);
            after_block(VECS[k][2:0], $sformatf("vec%0d", k));
        end

        // R8: frames past bit 15 are ignored
        held = {stat_pro, stat_copy, stat_orig};
        #(CLK_PERIOD/4);
        seen0 = upd_seen;
        for (int i = 0; i < 12; i++) put(1'b1, 1'b0, i[0], 1'b1, 1'b0);
        put(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        put(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        #(CLK_PERIOD/4);
        check("R8 trailing frames no update", upd_seen, seen0);
        check("R8 trailing frames hold flags", {29'd0, stat_pro, stat_copy, stat_orig}, {29'd0, held});

        // R9: cut-short block then full block
        #(CLK_PERIOD/4);
        seen0 = upd_seen;
        send_block(1'b0, 16'h8005, 16'h0000, 7, 0);
        send_block(1'b0, 16'h0200, 16'h8005, 16, 1);
        after_block(3'b001, "R9 restart");
        #(CLK_PERIOD/4);
        check("R9 exactly one update for restart pair", upd_seen, seen0 + 1);

        // R10: a block start pulse without frame_valid does not restart
        send_block(1'b1, 16'h0000, 16'h8004, 9, 0);
        put(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        for (int i = 9; i < 16; i++) put(1'b1, 1'b0, 1'b0, 1'b1, i == 15 ? 1'b1 : (i == 2));
        after_block(3'b011, "R10 invalid start ignored");

        // R1: reset again clears the register
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", {29'd0, stat_pro, stat_copy, stat_orig, 1'b0} >> 1, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        summary();
        $finish;
    end

endmodule